// File: doc/BRIEF.md
# Bit-Serial Transversal FIR Filter

This block is a finite impulse response filter in which every operation is one bit wide. Sample words enter on a single data wire, least significant bit first, at one bit per clock. Results leave the same way. Each of the `N_TAPS` taps has three parts: a shift-register delay exactly one word long, a serial-by-parallel multiplier whose coefficient is fixed at elaboration, and one input of a shared serial adder tree. The adder tree sums all tap products into one output stream.

A one-clock `word_start` pulse marks the least significant bit of every input word. The same pulse, delayed, clears the carries and sign-detect flops of the multipliers and of each adder-tree level just before that level sees a new word. The word delays are never cleared by it, so the past samples survive from word to word. The asynchronous reset clears everything. A cascade output carries the input stream after one more word delay past the last tap, so that a second filter can extend the tap count.

The stream runs at a fixed rate and has no back-pressure. The block consumes one data bit on every clock and produces one result bit on every clock. There is no valid or ready pair: framing is carried only by `word_start` and `out_word_start`.

Top module: `bsfir_filter`

## Requirements
- R1: The word length is W = DATA_W + COEF_W + ceil(log2(N_TAPS)). `word_start` is high for exactly one clock, on the LSB of each word. Words follow one another every W clocks. Each input sample is sign-extended from DATA_W bits to W bits before it is sent.
- R2: Result word m equals the sum over k of C_k times x[m-k], exact in W-bit two's complement. Tap k's coefficient is the signed field COEFS[k*COEF_W +: COEF_W].
- R3: The LSB of a result word appears L = ceil(log2(N_TAPS)) + 1 clocks after the clock on which the LSB of the matching input word is taken. `out_word_start` is high on that clock only.
- R4: C0 multiplies the newest word, and tap k multiplies the word received k word times earlier. A unit impulse therefore produces C0, C1, ... in successive result words.
- R5: `word_start` clears only the arithmetic. No carry or sign state passes from one word into the next, and the sample history in the word delays is kept.
- R6: After the reset is asserted, `dout`, `out_word_start` and `cascade_out` are 0, and the sample history is zero. The first results after reset use zero for every earlier sample.
- R7: `cascade_out` equals `din` delayed by N_TAPS*W clocks.
- R8: The most negative input sample combined with the most negative coefficient gives exact results, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole filter |
| word_start | input | 1 | High on the LSB clock of every input word |
| din | input | 1 | Serial sample input, LSB first, sign-extended to W bits |
| dout | output | 1 | Serial result output, LSB first, W bits per word |
| out_word_start | output | 1 | High on the LSB clock of every result word |
| cascade_out | output | 1 | Input stream delayed by N_TAPS words, for chaining |

## Verification
The bench builds the filter with five taps, 8-bit samples and 6-bit coefficients, giving W = 17 and L = 4. Five inputs leave an odd count at the first two tree levels, so both the plain pass-through flops and the clearing adders are used. Two of the coefficients are -32, the most negative 6-bit value, so the sign-bit stage of the multiplier is exercised in both its inverting and pass states. These words are driven alongside -128 samples and alternating large samples. A reset in the middle of the run shows that the history is flushed.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

  // Number of serial streams left after `lvl` pairing stages of a tree fed
  // by `n` streams (odd stream passes through a register).
  function automatic int level_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 1) / 2;
    return c;
  endfunction

endpackage

// File: rtl/bs_csa.sv
// Bit-serial adder: registered sum, carry held between bits of one word.
module bs_csa (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic a,
  input  logic b,
  output logic s
);
  logic cy_q;
  logic cy_in;
  logic s_d;
  logic cy_d;

  // on the LSB clock the stored carry belongs to the previous word
  assign cy_in = clr ? 1'b0 : cy_q;
  assign s_d   = a ^ b ^ cy_in;
  assign cy_d  = (a & b) | (a & cy_in) | (b & cy_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s    <= 1'b0;
      cy_q <= 1'b0;
    end else begin
      s    <= s_d;
      cy_q <= cy_d;
    end
  end

  AST_CSA_CARRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cy_q == ($past(a) & $past(b)))); // R5

endmodule

// File: rtl/bs_word_delay.sv
// One word of delay; never touched by the per-word clear.
module bs_word_delay #(
  parameter int LEN = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[LEN-2:0], d};
  end

  assign q = sr_q[LEN-1];

endmodule

// File: rtl/bs_serial_mult.sv
// Serial-by-constant multiplier. The MSB stage negates (sign weight), the
// lower stages add shifted partial products. One bit of latency.
module bs_serial_mult #(
  parameter int                COEF_W = 6,
  parameter logic [COEF_W-1:0] COEF   = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic y,
  output logic p
);
  localparam int MSB = COEF_W - 1;

  logic [COEF_W-1:0] st;
  logic neg_q;
  logic neg_in;
  logic top_bit;
  logic top_q;

  // sign stage: two's complement of y when the coefficient sign bit is set
  assign top_bit = y & COEF[MSB];
  assign neg_in  = clr ? 1'b0 : neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      top_q <= top_bit ^ neg_in;
      neg_q <= neg_in | top_bit;
    end
  end

  assign st[MSB] = top_q;

  for (genvar j = 0; j < MSB; j++) begin : g_stage
    logic up;
    logic pp;
    assign up = clr ? 1'b0 : st[j+1];
    assign pp = y & COEF[j];
    bs_csa u_add (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .a     (pp),
      .b     (up),
      .s     (st[j])
    );
  end

  assign p = st[0];

  AST_NEG_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(neg_q) |-> $past(clr)); // R5

endmodule

// File: rtl/bs_col_adder.sv
// Serial column adder: a tree of bit-serial adders, one level per clock.
module bs_col_adder
  import bsfir_pkg::*;
#(
  parameter int N_IN = 5,
  localparam int LVLS = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLS-1:0] clr_lvl,   // bit i clears level i+1
  input  logic [N_IN-1:0] din,
  output logic            sum
);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int CNT = level_count(N_IN, l);
    logic [CNT-1:0] s;

    if (l == 0) begin : g_in
      assign s = din;
    end else begin : g_red
      localparam int PCNT = level_count(N_IN, l - 1);
      for (genvar i = 0; i < CNT; i++) begin : g_node
        if (2*i + 1 < PCNT) begin : g_add
          bs_csa u_add (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_lvl[l-1]),
            .a     (g_lvl[l-1].s[2*i]),
            .b     (g_lvl[l-1].s[2*i+1]),
            .s     (s[i])
          );
        end else begin : g_pass
          logic pass_q;
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pass_q <= 1'b0;
            else        pass_q <= g_lvl[l-1].s[2*i];
          end
          assign s[i] = pass_q;
        end
      end
    end
  end

  assign sum = g_lvl[LVLS].s[0];

endmodule

// File: rtl/bsfir_filter.sv
module bsfir_filter #(
  parameter int N_TAPS = 5,
  parameter int DATA_W = 8,
  parameter int COEF_W = 6,
  parameter logic [N_TAPS*COEF_W-1:0] COEFS =
    {6'b100000, 6'b001101, 6'b111001, 6'b011111, 6'b100000}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_start,
  input  logic din,
  output logic dout,
  output logic out_word_start,
  output logic cascade_out
);
  localparam int LVLS   = $clog2(N_TAPS);
  localparam int WORD_W = DATA_W + COEF_W + LVLS;
  localparam int LAT    = LVLS + 1;
  localparam int GAP_W  = $clog2(WORD_W + 1);

  // delay chain: tap_in[k] feeds tap k, the last one is the cascade stream
  logic [N_TAPS:0]   tap_in;
  logic [N_TAPS-1:0] prod;
  logic [LAT-1:0]    ws_d;

  assign tap_in[0] = din;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    bs_word_delay #(.LEN(WORD_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tap_in[k]),
      .q     (tap_in[k+1])
    );
    bs_serial_mult #(
      .COEF_W (COEF_W),
      .COEF   (COEFS[k*COEF_W +: COEF_W])
    ) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (word_start),
      .y     (tap_in[k]),
      .p     (prod[k])
    );
  end

  assign cascade_out = tap_in[N_TAPS];

  // word marker pipeline: stage i lines up with tree level i+1
  if (LAT == 1) begin : g_ws1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ws_d <= '0;
      else        ws_d <= word_start;
    end
  end else begin : g_wsn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ws_d <= '0;
      else        ws_d <= {ws_d[LAT-2:0], word_start};
    end
  end

  if (N_TAPS == 1) begin : g_single
    assign dout = prod[0];
  end else begin : g_tree
    bs_col_adder #(.N_IN(N_TAPS)) u_tree (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_lvl (ws_d[LVLS-1:0]),
      .din     (prod),
      .sum     (dout)
    );
  end

  assign out_word_start = ws_d[LAT-1];

  // framing monitor for the input side
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_start) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (int'(gap_q) < WORD_W) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_WS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && seen_q) |-> (int'(gap_q) == WORD_W - 1)); // R1
  AST_OWS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> ##LAT out_word_start); // R3
  AST_OWS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_word_start |=> !out_word_start); // R3

endmodule

// File: tb/bsfir_filter_tb_top.sv
module bsfir_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_TAPS = 5;
  localparam int DATA_W = 8;
  localparam int COEF_W = 6;
  localparam int LVLS   = 3;
  localparam int WORD_W = DATA_W + COEF_W + LVLS;   // 17
  localparam int LAT    = LVLS + 1;                 // 4
  localparam int CF [N_TAPS] = '{-32, 31, -7, 13, -32};
  localparam logic [N_TAPS*COEF_W-1:0] COEFS =
    {6'b100000, 6'b001101, 6'b111001, 6'b011111, 6'b100000};
  localparam int NVEC = 20;
  // stimulus table; expected results come from the convolution model below
  localparam int SAMPLES [NVEC] = '{1, 0, 0, 0, 0, 0,
                                    -128, -128, -128, -128, -128,
                                    127, 127, 127, 127, 127,
                                    0, -1, 85, -86};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_start = 1'b0;
  logic din = 1'b0;
  logic dout, out_word_start, cascade_out;

  int n_chk = 0;
  int n_err = 0;
  int slot = 0;
  int nw = 0;
  int xw [0:255];
  string wtag [0:255];
  logic din_log [0:8191];
  logic [WORD_W-1:0] rxv;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsfir_filter #(
    .N_TAPS (N_TAPS), .DATA_W (DATA_W), .COEF_W (COEF_W), .COEFS (COEFS)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .word_start (word_start), .din (din),
    .dout (dout), .out_word_start (out_word_start), .cascade_out (cascade_out)
  );

  function automatic int expect_word(input int m);
    int acc = 0;
    for (int k = 0; k < N_TAPS; k++)
      if (m - k >= 0) acc += CF[k] * xw[m-k];
    return acc;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    n_err++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // checks made at the negedge that opens `slot`
  task automatic check_slot();
    if (slot >= LAT) begin
      int o = slot - LAT;
      int b = o % WORD_W;
      int m = o / WORD_W;
      n_chk++;
      if (out_word_start !== (b == 0)) fail("R3", "out_word_start", out_word_start, b == 0);
      rxv[b] = dout;
      if (b == WORD_W - 1 && m < nw) begin
        int e = expect_word(m);
        logic [WORD_W-1:0] ev = WORD_W'(e);
        n_chk++;
        if (rxv !== ev) fail(wtag[m], "result word", $signed(rxv), e);
      end
    end else begin
      n_chk++;   // R6: tree and marker start clear after reset
      if (dout !== 1'b0 || out_word_start !== 1'b0)
        fail("R6", "output before first result", {dout, out_word_start}, 0);
    end
    n_chk++;
    if (slot >= N_TAPS * WORD_W) begin
      if (cascade_out !== din_log[slot - N_TAPS*WORD_W])
        fail("R7", "cascade_out", cascade_out, din_log[slot - N_TAPS*WORD_W]);
    end else if (cascade_out !== 1'b0) begin
      fail("R6", "cascade_out after reset", cascade_out, 0);
    end
  endtask

  task automatic tick(input logic d, input logic ws);
    @(negedge clk);
    check_slot();
    din = d;
    word_start = ws;
    din_log[slot] = d;
    slot++;
  endtask

  // R1: sample sign-extended to WORD_W bits, LSB first, marker on bit 0
  task automatic send_word(input int x, input string tag);
    logic [31:0] xv = x;
    xw[nw] = x;
    wtag[nw] = tag;
    nw++;
    for (int t = 0; t < WORD_W; t++) tick(xv[t], t == 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    word_start = 1'b0;
    din = 1'b0;
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (dout !== 1'b0 || out_word_start !== 1'b0 || cascade_out !== 1'b0)
        fail("R6", "outputs in reset", {dout, out_word_start, cascade_out}, 0);
    end
    rst_n = 1'b1;
    slot = 0;
    nw = 0;
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    // table walk: impulse (R4), extremes (R8), history across words (R5)
    for (int i = 0; i < NVEC; i++)
      send_word(SAMPLES[i], (i < 6) ? "R4" : (i < 16) ? "R8" : "R5");
    // random signed samples (R1, R2)
    for (int i = 0; i < 12; i++)
      send_word(int'($urandom_range(0, 255)) - 128, i[0] ? "R1" : "R2");
    send_word(0, "R2");          // flush
    // mid-run reset: history must restart from zero (R6)
    do_reset();
    send_word(100, "R6");
    send_word(-77, "R6");
    send_word(0, "R6");
    send_word(0, "R6");          // flush
    tick(1'b0, 1'b0);
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

endmodule